// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

This block turns compare-match strobes from a time counter into a timed output pulse train. A single-cycle compare strobe arms the generator. The generator counts a programmed start delay in counter ticks, then drives the sync output high for a programmed width. If the period register is zero, each compare strobe gives exactly one pulse. If the period is nonzero, the pulse repeats every period ticks for as long as the generator stays enabled.

Software sets up the generator through a small register interface. Writes are synchronous and reads are combinational. The interface holds a two-bit control word, the width, the period, the start delay and a sticky status flag. Software clears the control word while the time counter is being rewritten, so any disable sends the generator straight back to idle and silences the output.

Top module: `sync_pulse_gen`

## Requirements
- R1: After reset the sync output is low and every register reads as zero.
- R2: The generator is enabled only when control bits 0 and 1 (address 0) are both 1. When either bit is 0, the sync output is low in the cycle after the write and the generator is idle. No pulse resumes on re-enable until a new compare strobe arrives.
- R3: A compare strobe is accepted only when the generator is enabled and idle. If the strobe is sampled at clock edge k, the output rises after edge k+S, where S is the start delay (address 3, in ticks, 0 allowed).
- R4: Each pulse stays high for W cycles, where W is the width at address 1.
- R5: With a period (address 2) of 0, one accepted strobe yields exactly one pulse.
- R6: With a nonzero period P, successive rising edges are exactly P cycles apart while the generator stays enabled.
- R7: A compare strobe that arrives while a delay, pulse or gap is in progress is ignored.
- R8: A width of 0 produces no pulse.
- R9: If the period P is nonzero and the width is at least P, the pulse width is P-1. With P=1 this gives no pulse.
- R10: Status bit 0 (address 4) is set at every pulse start and is cleared by writing 1 to it. When a pulse start and a clearing write fall on the same edge, the bit stays set.
- R11: Reads of unmapped addresses (5 to 7) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one counter tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Combinational read data |
| cmpEvent | input | 1 | Single-cycle compare-match strobe |
| syncOut | output | 1 | Sync pulse output |

## Verification
Two events can fall on the same edge: a pulse start, which sets the status flag, and a software write of 1 that clears it. The bench provokes this with a start delay of 2. It issues the clearing write two cycles after the compare strobe, so the write is sampled on the very edge where the pulse begins. It then expects the flag to read 1. A plain clearing write later must bring the flag to 0. A second overlap is a fresh compare strobe that arrives during the delay or the pulse. The bench judges this by counting rising edges over the whole window.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2,
    ST_GAP   = 2'd3
  } spgState_e;

  typedef struct packed {
    logic clear;
    logic loadDelay;
    logic loadWidth;
    logic loadGap;
    logic decr;
  } spgStrobe_t;

  localparam int CTRL_ADDR   = 0;
  localparam int WIDTH_ADDR  = 1;
  localparam int PERIOD_ADDR = 2;
  localparam int START_ADDR  = 3;
  localparam int STATUS_ADDR = 4;
endpackage

// File: rtl/spg_datapath.sv
module spg_datapath
  import spg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  spgStrobe_t        strobe,
  output logic              syncActive,
  output logic              widthZero,
  output logic              startZero,
  output logic              periodZero,
  output logic              cntLast,
  output logic              statusBit
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [1:0]        ctrlReg;
  logic [DATA_W-1:0] widthReg, periodReg, startReg, cnt, widthEff;
  logic              wrCtrl, wrWidth, wrPeriod, wrStart, wrStatus;

  assign wrCtrl   = regWr && (regAddr == ADDR_W'(CTRL_ADDR));
  assign wrWidth  = regWr && (regAddr == ADDR_W'(WIDTH_ADDR));
  assign wrPeriod = regWr && (regAddr == ADDR_W'(PERIOD_ADDR));
  assign wrStart  = regWr && (regAddr == ADDR_W'(START_ADDR));
  assign wrStatus = regWr && (regAddr == ADDR_W'(STATUS_ADDR));

  always_comb begin
    if (periodReg != '0 && widthReg >= periodReg) widthEff = periodReg - ONE;
    else widthEff = widthReg;
  end

  assign syncActive = ctrlReg[0] & ctrlReg[1];
  assign widthZero  = (widthEff == '0);
  assign startZero  = (startReg == '0);
  assign periodZero = (periodReg == '0);
  assign cntLast    = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      widthReg  <= '0;
      periodReg <= '0;
      startReg  <= '0;
    end else begin
      if (wrCtrl)   ctrlReg   <= regWdata[1:0];
      if (wrWidth)  widthReg  <= regWdata;
      if (wrPeriod) periodReg <= regWdata;
      if (wrStart)  startReg  <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.clear)     cnt <= '0;
    else if (strobe.loadDelay) cnt <= startReg;
    else if (strobe.loadWidth) cnt <= widthEff;
    else if (strobe.loadGap)   cnt <= periodReg - widthEff;
    else if (strobe.decr)      cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         statusBit <= 1'b0;
    else if (strobe.loadWidth)         statusBit <= 1'b1;
    else if (wrStatus && regWdata[0])  statusBit <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(CTRL_ADDR))        regRdata = DATA_W'(ctrlReg);
    else if (regAddr == ADDR_W'(WIDTH_ADDR))  regRdata = widthReg;
    else if (regAddr == ADDR_W'(PERIOD_ADDR)) regRdata = periodReg;
    else if (regAddr == ADDR_W'(START_ADDR))  regRdata = startReg;
    else if (regAddr == ADDR_W'(STATUS_ADDR)) regRdata = DATA_W'(statusBit);
  end
endmodule

// File: rtl/spg_control.sv
module spg_control
  import spg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpEvent,
  input  logic       syncActive,
  input  logic       widthZero,
  input  logic       startZero,
  input  logic       periodZero,
  input  logic       cntLast,
  output spgStrobe_t strobe,
  output logic       inPulse,
  output logic       busy
);
  spgState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!syncActive) begin
      stateNext    = ST_IDLE;
      strobe.clear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmpEvent && !widthZero) begin
            if (startZero) begin
              stateNext        = ST_PULSE;
              strobe.loadWidth = 1'b1;
            end else begin
              stateNext        = ST_DELAY;
              strobe.loadDelay = 1'b1;
            end
          end
        end
        ST_DELAY: begin
          if (cntLast) begin
            stateNext        = ST_PULSE;
            strobe.loadWidth = 1'b1;
          end else strobe.decr = 1'b1;
        end
        ST_PULSE: begin
          if (cntLast) begin
            if (periodZero) begin
              stateNext    = ST_IDLE;
              strobe.clear = 1'b1;
            end else begin
              stateNext      = ST_GAP;
              strobe.loadGap = 1'b1;
            end
          end else strobe.decr = 1'b1;
        end
        default: begin
          if (cntLast) begin
            if (widthZero || periodZero) begin
              stateNext    = ST_IDLE;
              strobe.clear = 1'b1;
            end else begin
              stateNext        = ST_PULSE;
              strobe.loadWidth = 1'b1;
            end
          end else strobe.decr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inPulse = (state == ST_PULSE);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import spg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              cmpEvent,
  output logic              syncOut
);
  spgStrobe_t strobe;
  logic syncActive, widthZero, startZero, periodZero, cntLast, statusBit;
  logic inPulse, busy;

  spg_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .syncActive(syncActive), .widthZero(widthZero), .startZero(startZero),
    .periodZero(periodZero), .cntLast(cntLast), .statusBit(statusBit)
  );

  spg_control u_ctl (
    .clk(clk), .rstN(rstN), .cmpEvent(cmpEvent), .syncActive(syncActive),
    .widthZero(widthZero), .startZero(startZero), .periodZero(periodZero),
    .cntLast(cntLast), .strobe(strobe), .inPulse(inPulse), .busy(busy)
  );

  assign syncOut = inPulse & syncActive;
endmodule

// File: rtl/spg_checker.sv
module spg_checker (
  input logic clk,
  input logic rstN,
  input logic cmpEvent,
  input logic syncOut,
  input logic syncActive,
  input logic busy,
  input logic statusBit,
  input logic periodZero,
  input logic widthZero
);
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !syncActive |-> !syncOut);

  a_r3_no_spontaneous: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cmpEvent) |=> !syncOut);

  a_r8_zero_width: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && widthZero) |=> !syncOut);

  a_r10_status_on_issue: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> statusBit);

  a_r5_oneshot_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(syncOut) && syncActive && $past(periodZero)) |-> !busy);
endmodule

bind sync_pulse_gen spg_checker u_chk (
  .clk(clk), .rstN(rstN), .cmpEvent(cmpEvent), .syncOut(syncOut),
  .syncActive(syncActive), .busy(busy), .statusBit(statusBit),
  .periodZero(periodZero), .widthZero(widthZero)
);

// File: tb/sync_pulse_gen_tb.sv
module sync_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        cmpEvent = 1'b0;
  logic        syncOut;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sync_pulse_gen u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cmpEvent(cmpEvent),
    .syncOut(syncOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'(a); regWdata = 16'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input int a, output int d);
    @(negedge clk);
    regAddr = 3'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic setup(input int w, input int p, input int s);
    writeReg(0, 0);
    writeReg(1, w);
    writeReg(2, p);
    writeReg(3, s);
    writeReg(0, 3);
  endtask

  task automatic runEvent(input int extraAt, input int window, output int firstRise,
                          output int firstLen, output int rises, output int secondRise);
    bit prev;
    firstRise = -1; secondRise = -1; firstLen = 0; rises = 0; prev = 1'b0;
    @(negedge clk);
    cmpEvent = 1'b1;
    for (int i = 1; i <= window; i++) begin
      @(negedge clk);
      cmpEvent = (i == extraAt);
      if (syncOut && !prev) begin
        rises++;
        if (rises == 1) firstRise = i;
        else if (rises == 2) secondRise = i;
      end
      if (syncOut && rises == 1) firstLen++;
      prev = syncOut;
    end
    cmpEvent = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, fr, fl, rs, sr, eff;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(syncOut == 1'b0, "R1 output low", int'(syncOut), 0);
    for (int a = 0; a < 5; a++) begin
      readReg(a, d);
      check(d == 0, "R1 register zero", d, 0);
    end
    rstN = 1'b1;

    // R11 readback and unmapped addresses
    writeReg(1, 16'h1234);
    readReg(1, d);
    check(d == 16'h1234, "R11 width readback", d, 16'h1234);
    for (int a = 5; a < 8; a++) begin
      readReg(a, d);
      check(d == 0, "R11 unmapped reads zero", d, 0);
    end

    // R3 R4 R5 one-shot sweep over start and width
    for (int s = 0; s < 4; s++) begin
      for (int w = 1; w < 5; w++) begin
        setup(w, 0, s);
        runEvent(-1, s + w + 6, fr, fl, rs, sr);
        check(fr == s + 1, "R3 rise after start delay", fr, s + 1);
        check(fl == w, "R4 pulse width", fl, w);
        check(rs == 1, "R5 single pulse", rs, 1);
      end
    end

    // R6 R9 periodic sweep with clamp
    for (int p = 1; p < 6; p++) begin
      for (int w = 1; w < 7; w++) begin
        eff = (w >= p) ? p - 1 : w;
        setup(w, p, 1);
        runEvent(-1, 1 + 2 * p + 3, fr, fl, rs, sr);
        if (eff == 0) begin
          check(rs == 0, "R9 clamp to zero gives no pulse", rs, 0);
        end else begin
          check(fl == eff, "R9 clamped width", fl, eff);
          check(sr - fr == p, "R6 repeat spacing", sr - fr, p);
        end
      end
    end

    // R8 zero width
    setup(0, 0, 0);
    runEvent(-1, 8, fr, fl, rs, sr);
    check(rs == 0, "R8 zero width no pulse", rs, 0);

    // R7 event during delay and during pulse ignored
    setup(4, 0, 3);
    runEvent(2, 16, fr, fl, rs, sr);
    check(rs == 1, "R7 event in delay ignored", rs, 1);
    check(fl == 4, "R7 pulse unchanged", fl, 4);
    runEvent(5, 16, fr, fl, rs, sr);
    check(rs == 1, "R7 event in pulse ignored", rs, 1);

    // R2 disable mid-train
    setup(2, 4, 0);
    @(negedge clk); cmpEvent = 1'b1;
    @(negedge clk); cmpEvent = 1'b0;
    while (!syncOut) @(negedge clk);
    writeReg(0, 0);
    check(syncOut == 1'b0, "R2 output drops next cycle", int'(syncOut), 0);
    writeReg(0, 3);
    rs = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (syncOut) rs++;
    end
    check(rs == 0, "R2 no resume after re-enable", rs, 0);
    writeReg(0, 1);
    runEvent(-1, 8, fr, fl, rs, sr);
    check(rs == 0, "R2 bit1 clear blocks", rs, 0);
    writeReg(0, 2);
    runEvent(-1, 8, fr, fl, rs, sr);
    check(rs == 0, "R2 bit0 clear blocks", rs, 0);

    // R10 status clear and collision
    setup(3, 0, 2);
    writeReg(4, 1);
    readReg(4, d);
    check(d == 0, "R10 write one clears", d, 0);
    @(negedge clk); cmpEvent = 1'b1;
    @(negedge clk); cmpEvent = 1'b0;
    @(negedge clk); regWr = 1'b1; regAddr = 3'd4; regWdata = 16'd1;
    @(negedge clk); regWr = 1'b0;
    readReg(4, d);
    check(d == 1, "R10 set wins over clear", d, 1);
    repeat (6) @(negedge clk);
    writeReg(4, 0);
    readReg(4, d);
    check(d == 1, "R10 write zero keeps", d, 1);
    writeReg(4, 1);
    readReg(4, d);
    check(d == 0, "R10 cleared", d, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule